// File: doc/BRIEF.md
# Two-speed start-up clock controller

This block chooses the clock that feeds the core and peripherals when the chip comes out of power-on or sleep. When a crystal is fitted, the crystal needs time to settle. Until then the core runs from the internal oscillator. A start-up timer counts falling edges of the crystal, and once the crystal is judged stable the block hands the system clock over to it without producing a runt pulse.

Both oscillators arrive as raw square waves. They are resampled in a fast reference clock domain, which must run at least four times faster than either oscillator. The system clock is rebuilt there from the synchronized levels. Any change of source happens only at falling edges: the old source is dropped after it goes low, and the new source is picked up after its own falling edge.

The handover order is fixed. First the timer expires. Then the block waits for an internal falling edge, raises the status flag and holds the clock low. It then waits for an external falling edge and runs from the external source. A sleep request aborts any start-up in progress. A select bit can be written by software. Automatic source changes never alter that bit.

Top module: `two_speed_clk_ctrl`

## Requirements
- R1: After reset, sys_clk_o, osts_o, src_ext_o and sel_o are all 0. sys_clk_o stays low until a start_i pulse.
- R2: Two-speed start-up applies when dual_en_i=1, sel_o=0 and osc_mode_i is 0, 1 or 2 (the crystal modes). In that case, after start_i, sys_clk_o follows the internal oscillator and osts_o and src_ext_o stay 0 while the timer counts.
- R3: osts_o rises only after the start-up timer has seen exactly 1024 external falling edges since start_i. It rises before the next external falling edge. The 11-bit count saturates at 1024.
- R4: Handover order: osts_o rises while sys_clk_o is low, sys_clk_o stays low until src_ext_o rises, and sys_clk_o then toggles at the external oscillator rate.
- R5: A one-cycle sleep_i pulse forces sys_clk_o low and clears osts_o and src_ext_o on the next cycle. A sleep during counting aborts the count, and the next start_i counts a full 1024 edges again.
- R6: In a crystal mode with dual_en_i=0 and sel_o=0, sys_clk_o is held low during the count. The clock then hands over to the external source as in R4.
- R7: With osc_mode_i in 3..7 and sel_o=0, no count is made: after start_i the block runs from the external oscillator from its next falling edge, with osts_o=1.
- R8: With sel_o=1 the internal oscillator drives sys_clk_o and osts_o=0. Setting sel_o to 1 while running externally switches back after an external falling edge and then an internal falling edge.
- R9: Clearing sel_o while running internally in a crystal mode restarts the 1024-edge count. The internal clock keeps running during the count, and the block then hands over to the external source.
- R10: sel_o changes only on a sel_wr_i strobe, which loads sel_val_i. Reset clears it. Automatic source changes never modify it.
- R11: Outside sleep and reset, no high or low phase of sys_clk_o is shorter than the shorter oscillator half-period. In particular, no phase is shorter than one reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Fast reference clock that samples both oscillators |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_osc_i | input | 1 | Raw internal oscillator |
| ext_osc_i | input | 1 | Raw external oscillator |
| osc_mode_i | input | 3 | External mode; 0..2 crystal, 3..7 no start-up needed |
| dual_en_i | input | 1 | Two-speed start-up enable |
| sel_wr_i | input | 1 | Strobe loading the select bit |
| sel_val_i | input | 1 | Value written to the select bit |
| start_i | input | 1 | One-cycle pulse: power-up delay done or wake |
| sleep_i | input | 1 | One-cycle pulse: enter sleep |
| sys_clk_o | output | 1 | Gated system clock |
| osts_o | output | 1 | Start-up status: external source selected |
| src_ext_o | output | 1 | External oscillator is driving sys_clk_o |
| sel_o | output | 1 | Software select bit (1 = internal) |

## Verification
If the source state machine sits in the wrong state, the rate or level of sys_clk_o changes within a few oscillator periods. It would run at the internal rate where the external rate is expected, or stay low where it should toggle. A start-up counter that is off by even one edge shows as osts_o rising one external period early or late, so the bench lines up start_i with a known external phase and compares the raw edge count exactly. A handover out of order shows in under one oscillator period, as a clock high while the flag is set but the source is not yet external, or as a phase shorter than the shorter half-period.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,  // reset or sleep, clock stopped
    ST_INT       = 3'd1,  // running internal
    ST_CNT       = 3'd2,  // start-up count in progress
    ST_INT_FALL  = 3'd3,  // count done, wait internal fall
    ST_HOLD      = 3'd4,  // clock held low, wait external fall
    ST_EXT       = 3'd5,  // running external
    ST_EXT_FALL  = 3'd6,  // leaving external, wait external fall
    ST_INT_WAIT  = 3'd7   // clock low, wait internal fall
  } tsu_state_e;

  localparam logic [2:0] MODE_XT_LOW  = 3'd0;
  localparam logic [2:0] MODE_XT_STD  = 3'd1;
  localparam logic [2:0] MODE_XT_FAST = 3'd2;

  function automatic logic mode_is_xtal(input logic [2:0] m);
    return (m == MODE_XT_LOW) || (m == MODE_XT_STD) || (m == MODE_XT_FAST);
  endfunction

endpackage

// File: rtl/tsu_osc_sync.sv
module tsu_osc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  output logic lvl_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], osc_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign fall_o = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/tsu_ost_cnt.sv
module tsu_ost_cnt #(
  parameter int unsigned LIMIT = 1024,
  parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);

  localparam logic [CW-1:0] TERM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != TERM) cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == TERM);

endmodule

// File: rtl/tsu_src_fsm.sv
module tsu_src_fsm
  import tsu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       sleep_i,
  input  logic       sel_i,
  input  logic       xtal_i,
  input  logic       dual_en_i,
  input  logic       int_fall_i,
  input  logic       ext_fall_i,
  input  logic       ost_done_i,
  output tsu_state_e state_o,
  output logic       cnt_clr_o,
  output logic       gate_low_o
);

  tsu_state_e state_q, state_d;
  logic       gate_q, gate_d;
  logic       clr;

  always_comb begin
    state_d = state_q;
    gate_d  = gate_q;
    clr     = 1'b0;
    if (sleep_i) begin
      state_d = ST_OFF;
      clr     = 1'b1;
    end else begin
      case (state_q)
        ST_OFF: if (start_i) begin
          clr = 1'b1;
          if (sel_i)       state_d = ST_INT_WAIT;
          else if (xtal_i) begin
            state_d = ST_CNT;
            gate_d  = ~dual_en_i;  // no two-speed: core waits with clock low
          end
          else             state_d = ST_HOLD;
        end
        ST_INT: if (!sel_i) begin
          if (xtal_i) begin
            state_d = ST_CNT;
            gate_d  = 1'b0;
            clr     = 1'b1;
          end else begin
            state_d = ST_INT_FALL;
          end
        end
        ST_CNT: begin
          if (sel_i)           state_d = gate_q ? ST_INT_WAIT : ST_INT;
          else if (ost_done_i) state_d = gate_q ? ST_HOLD : ST_INT_FALL;
        end
        ST_INT_FALL: begin
          if (sel_i)           state_d = ST_INT;
          else if (int_fall_i) state_d = ST_HOLD;
        end
        ST_HOLD: begin
          if (sel_i)           state_d = ST_INT_WAIT;
          else if (ext_fall_i) state_d = ST_EXT;
        end
        ST_EXT: if (sel_i) state_d = ST_EXT_FALL;
        ST_EXT_FALL: begin
          if (!sel_i)          state_d = ST_EXT;
          else if (ext_fall_i) state_d = ST_INT_WAIT;
        end
        ST_INT_WAIT: if (int_fall_i) state_d = ST_INT;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gate_q  <= gate_d;
    end
  end

  assign state_o    = state_q;
  assign cnt_clr_o  = clr;
  assign gate_low_o = gate_q;

endmodule

// File: rtl/two_speed_clk_ctrl.sv
module two_speed_clk_ctrl
  import tsu_pkg::*;
#(
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       ref_clk_i,
  input  logic       rst_ni,
  input  logic       int_osc_i,
  input  logic       ext_osc_i,
  input  logic [2:0] osc_mode_i,
  input  logic       dual_en_i,
  input  logic       sel_wr_i,
  input  logic       sel_val_i,
  input  logic       start_i,
  input  logic       sleep_i,
  output logic       sys_clk_o,
  output logic       osts_o,
  output logic       src_ext_o,
  output logic       sel_o
);

  localparam int unsigned CNT_W   = $clog2(OST_CYCLES + 1);
  localparam int unsigned N_OSC   = 2;
  localparam int unsigned OSC_INT = 0;
  localparam int unsigned OSC_EXT = 1;

  logic [N_OSC-1:0] osc_raw, osc_lvl, osc_fall;
  tsu_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_clr, ost_done, gate_low;
  logic             sel_q, arm_q, clk_q, clk_d;

  assign osc_raw[OSC_INT] = int_osc_i;
  assign osc_raw[OSC_EXT] = ext_osc_i;

  for (genvar g = 0; g < N_OSC; g++) begin : g_osc
    tsu_osc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (ref_clk_i),
      .rst_ni (rst_ni),
      .osc_i  (osc_raw[g]),
      .lvl_o  (osc_lvl[g]),
      .fall_o (osc_fall[g])
    );
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= 1'b0;
    else if (sel_wr_i) sel_q <= sel_val_i;
  end

  tsu_src_fsm u_fsm (
    .clk_i      (ref_clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sleep_i    (sleep_i),
    .sel_i      (sel_q),
    .xtal_i     (mode_is_xtal(osc_mode_i)),
    .dual_en_i  (dual_en_i),
    .int_fall_i (osc_fall[OSC_INT]),
    .ext_fall_i (osc_fall[OSC_EXT]),
    .ost_done_i (ost_done),
    .state_o    (state_q),
    .cnt_clr_o  (cnt_clr),
    .gate_low_o (gate_low)
  );

  tsu_ost_cnt #(.LIMIT(OST_CYCLES), .CW(CNT_W)) u_ost (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .tick_i (osc_fall[OSC_EXT] && state_q == ST_CNT),
    .cnt_o  (cnt_q),
    .done_o (ost_done)
  );

  // internal clock passes only after a falling edge seen since leaving OFF
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)                    arm_q <= 1'b0;
    else if (state_q == ST_OFF)     arm_q <= 1'b0;
    else if (osc_fall[OSC_INT])     arm_q <= 1'b1;
  end

  always_comb begin
    case (state_q)
      ST_INT, ST_INT_FALL: clk_d = arm_q & osc_lvl[OSC_INT];
      ST_CNT:              clk_d = ~gate_low & arm_q & osc_lvl[OSC_INT];
      ST_EXT, ST_EXT_FALL: clk_d = osc_lvl[OSC_EXT];
      default:             clk_d = 1'b0;
    endcase
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_q <= 1'b0;
    else         clk_q <= clk_d;
  end

  assign sys_clk_o = clk_q;
  assign osts_o    = (state_q == ST_HOLD) || (state_q == ST_EXT) || (state_q == ST_EXT_FALL);
  assign src_ext_o = (state_q == ST_EXT) || (state_q == ST_EXT_FALL);
  assign sel_o     = sel_q;

endmodule

// File: rtl/tsu_checker.sv
module tsu_checker
  import tsu_pkg::*;
#(
  parameter int unsigned LIMIT = 1024,
  parameter int unsigned CW    = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sleep_i,
  input logic          sel_wr_i,
  input logic [2:0]    osc_mode_i,
  input logic          sys_clk_o,
  input logic          osts_o,
  input logic          src_ext_o,
  input logic          sel_o,
  input tsu_state_e    state_i,
  input logic [CW-1:0] cnt_i
);

  p_hold_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HOLD && $past(state_i == ST_HOLD)) |-> !sys_clk_o);

  p_flag_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(src_ext_o) |-> $past(osts_o));

  p_count_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(osts_o) && mode_is_xtal(osc_mode_i)) |-> (cnt_i == CW'(LIMIT)));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(LIMIT));

  p_sleep_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!osts_o && !src_ext_o));

  p_sel_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr_i |=> $stable(sel_o));

endmodule

bind two_speed_clk_ctrl tsu_checker #(.LIMIT(OST_CYCLES), .CW(CNT_W)) u_chk (
  .clk_i      (ref_clk_i),
  .rst_ni     (rst_ni),
  .sleep_i    (sleep_i),
  .sel_wr_i   (sel_wr_i),
  .osc_mode_i (osc_mode_i),
  .sys_clk_o  (sys_clk_o),
  .osts_o     (osts_o),
  .src_ext_o  (src_ext_o),
  .sel_o      (sel_o),
  .state_i    (state_q),
  .cnt_i      (cnt_q)
);

// File: tb/tb_two_speed_clk_ctrl.sv
module tb_two_speed_clk_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int INT_HALF   = 3;
  localparam int EXT_HALF   = 7;
  localparam int OST        = 1024;
  localparam int MIN_PHASE  = 3;

  logic       ref_clk = 1'b0;
  logic       rst_ni  = 1'b0;
  logic       int_osc = 1'b0;
  logic       ext_osc = 1'b0;
  logic [2:0] mode    = 3'd1;
  logic       dual_en = 1'b1;
  logic       sel_wr  = 1'b0;
  logic       sel_val = 1'b0;
  logic       start   = 1'b0;
  logic       sleep   = 1'b0;
  logic       sys_clk, osts, src_ext, sel_o;

  two_speed_clk_ctrl dut (
    .ref_clk_i  (ref_clk),
    .rst_ni     (rst_ni),
    .int_osc_i  (int_osc),
    .ext_osc_i  (ext_osc),
    .osc_mode_i (mode),
    .dual_en_i  (dual_en),
    .sel_wr_i   (sel_wr),
    .sel_val_i  (sel_val),
    .start_i    (start),
    .sleep_i    (sleep),
    .sys_clk_o  (sys_clk),
    .osts_o     (osts),
    .src_ext_o  (src_ext),
    .sel_o      (sel_o)
  );

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  int n_tests = 0, n_fail = 0;
  int int_ph = 0, ext_ph = 0, ext_falls = 0;

  always @(negedge ref_clk) begin
    if (int_ph == INT_HALF-1) begin int_ph <= 0; int_osc <= ~int_osc; end
    else int_ph <= int_ph + 1;
    if (ext_ph == EXT_HALF-1) begin
      ext_ph  <= 0;
      ext_osc <= ~ext_osc;
      if (ext_osc) ext_falls <= ext_falls + 1;
    end else ext_ph <= ext_ph + 1;
  end

  logic prev_clk = 1'b0, prev_osts = 1'b0;
  bit   run_ok = 1'b0, in_hold = 1'b0;
  int   run = 0, clk_rises = 0, short_cnt = 0, hold_bad = 0, osts_snap = 0;

  always @(negedge ref_clk) begin
    if (sys_clk !== prev_clk) begin
      if (run_ok && run < MIN_PHASE) short_cnt <= short_cnt + 1;
      run    <= 1;
      run_ok <= rst_ni && !sleep;
      if (sys_clk) clk_rises <= clk_rises + 1;
    end else begin
      run <= run + 1;
      if (!rst_ni || sleep) run_ok <= 1'b0;
    end
    prev_clk <= sys_clk;
    if (osts && !prev_osts) begin
      osts_snap <= ext_falls;
      if (!src_ext) in_hold <= 1'b1;
    end
    if (src_ext || !osts) in_hold <= 1'b0;
    if (in_hold && sys_clk) hold_bad <= hold_bad + 1;
    prev_osts <= osts;
  end

  function automatic int exp_rises(input int window, input int half);
    return window / (2 * half);
  endfunction

  function automatic bit near(input int act, input int exp);
    return (act >= exp - 1) && (act <= exp + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic rises_in(input int window, output int r);
    int r0;
    r0 = clk_rises;
    cyc(window);
    r = clk_rises - r0;
  endtask

  task automatic align_ext();
    do @(negedge ref_clk); while (!(ext_osc && ext_ph == 2));
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge ref_clk);
    start = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep = 1'b1;
    @(negedge ref_clk);
    sleep = 1'b0;
  endtask

  task automatic write_sel(input logic v);
    sel_wr  = 1'b1;
    sel_val = v;
    @(negedge ref_clk);
    sel_wr  = 1'b0;
  endtask

  task automatic wait_osts(input int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge ref_clk);
      if (osts) seen = 1'b1;
    end
    cyc(1);
  endtask

  initial begin
    repeat (195000) @(posedge ref_clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int r, base, d;
    bit seen;
    void'($urandom(32'd20240611));

    // R1 reset state
    cyc(4);
    chk({sys_clk, osts, src_ext, sel_o} == 4'b0, "R1", "outputs in reset",
        {sys_clk, osts, src_ext, sel_o}, 0);
    rst_ni = 1'b1;
    rises_in(60, r);
    chk(r == 0, "R1", "clock idle before start", r, 0);

    // R2/R3/R4 two-speed, standard crystal
    mode = 3'd1; dual_en = 1'b1;
    align_ext();
    base = ext_falls;
    pulse_start();
    cyc(40);
    chk(!osts && !src_ext, "R2", "flags during count", {osts, src_ext}, 0);
    rises_in(120, r);
    chk(near(r, exp_rises(120, INT_HALF)), "R2", "internal rate", r, exp_rises(120, INT_HALF));
    wait_osts(16000, seen);
    chk(seen, "R3", "status rises", seen, 1);
    chk(osts_snap - base == OST, "R3", "external edges before status", osts_snap - base, OST);
    cyc(40);
    chk(src_ext, "R4", "external source", src_ext, 1);
    rises_in(140, r);
    chk(near(r, exp_rises(140, EXT_HALF)), "R4", "external rate", r, exp_rises(140, EXT_HALF));
    chk(sel_o == 1'b0, "R10", "select unchanged by auto switch", sel_o, 0);

    // R5 sleep and aborted counts
    pulse_sleep();
    cyc(3);
    chk({sys_clk, osts, src_ext} == 3'b0, "R5", "sleep from external", {sys_clk, osts, src_ext}, 0);
    for (int k = 0; k < 3; k++) begin
      pulse_start();
      d = (k == 0) ? 1 : 50 + int'($urandom % 9000);
      cyc(d);
      chk(!osts, "R5", "no status before count ends", osts, 0);
      pulse_sleep();
      cyc(3);
      chk({osts, src_ext} == 2'b0, "R5", "abort clears flags", {osts, src_ext}, 0);
      rises_in(60, r);
      chk(r == 0, "R5", "clock stopped in sleep", r, 0);
    end

    // R6 crystal without two-speed, full recount after abort (R5)
    mode = 3'd0; dual_en = 1'b0;
    align_ext();
    base = ext_falls;
    pulse_start();
    rises_in(300, r);
    chk(r == 0, "R6", "clock held low during count", r, 0);
    wait_osts(16000, seen);
    chk(seen && osts_snap - base == OST, "R5", "full recount after sleep", osts_snap - base, OST);
    cyc(40);
    chk(src_ext, "R6", "then external", src_ext, 1);

    // R7 non-crystal mode
    pulse_sleep();
    mode = 3'd5; dual_en = 1'b1;
    cyc(5);
    pulse_start();
    cyc(40);
    chk(osts && src_ext, "R7", "external without count", {osts, src_ext}, 3);
    rises_in(140, r);
    chk(near(r, exp_rises(140, EXT_HALF)), "R7", "external rate", r, exp_rises(140, EXT_HALF));

    // R8 software select to internal
    write_sel(1'b1);
    cyc(40);
    chk({osts, src_ext, sel_o} == 3'b001, "R8", "back on internal", {osts, src_ext, sel_o}, 1);
    rises_in(120, r);
    chk(near(r, exp_rises(120, INT_HALF)), "R8", "internal rate", r, exp_rises(120, INT_HALF));

    // R1/R10 reset clears select
    rst_ni = 1'b0;
    cyc(3);
    chk({sys_clk, osts, src_ext, sel_o} == 4'b0, "R10", "reset clears select",
        {sys_clk, osts, src_ext, sel_o}, 0);
    rst_ni = 1'b1;
    cyc(5);

    // R8/R9 start on internal, then release select in crystal mode
    mode = 3'd2; dual_en = 1'b1;
    write_sel(1'b1);
    pulse_start();
    cyc(3000);
    chk(!osts && !src_ext, "R8", "select holds internal", {osts, src_ext}, 0);
    rises_in(120, r);
    chk(near(r, exp_rises(120, INT_HALF)), "R8", "internal rate", r, exp_rises(120, INT_HALF));
    align_ext();
    base = ext_falls;
    write_sel(1'b0);
    rises_in(120, r);
    chk(near(r, exp_rises(120, INT_HALF)), "R9", "clock runs during recount", r, exp_rises(120, INT_HALF));
    wait_osts(16000, seen);
    chk(seen && osts_snap - base == OST, "R9", "recount length", osts_snap - base, OST);
    cyc(40);
    chk(src_ext && !sel_o, "R9", "external after recount", {src_ext, sel_o}, 2);

    // R11/R4 phase lengths and hold window over whole run
    chk(short_cnt == 0, "R11", "short clock phases", short_cnt, 0);
    chk(hold_bad == 0, "R4", "clock high during hold", hold_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule